// File: doc/BRIEF.md
# DMA Channel Register Bank with Semaphores

This block is the register file of a multi-channel DMA controller. Software reaches it through a plain 32-bit register port: a write strobe, a byte address, write data, and read data that follows the address combinationally. The bank decodes five global registers and one repeated block of registers for each channel. Each block carries its own 8-bit semaphore count.

The channel engines live outside the bank. Each engine reports a finished descriptor with a completion pulse and with a flag telling whether that descriptor asked for an interrupt. Each engine also sends a decrement pulse when it consumes a semaphore credit. The bank turns these events into latched status, interrupt lines gated by per-channel enables, and one-cycle start requests back to the engines.

A register is selected by address bits 4 and up, so every register spans 16 bytes and address bits [3:0] are ignored. Bits 16..16+NUM_CH-1 of control 1 hold the interrupt enables and bits 0..NUM_CH-1 hold the status. All other control 1 bits read as zero.

Top module: `dma_regbank`

## Requirements
- R1: The global registers sit at byte offsets 0x00 (control 0), 0x10 (control 1), 0x20 (control 2), 0x30 (select A) and 0x40 (select B). Control 2 and both select registers store all 32 written bits and read them back.
- R2: Channel n owns offsets CH_BASE+n*0x70+k*0x10, where k runs 0..6. The word order is current command, next command, command, buffer address, semaphore, debug 1, debug 2. The first four words store 32 bits and read them back. Both debug words read as zero.
- R3: A write to a channel's semaphore word adds write data bits [7:0] to that channel's count, modulo 256. The word reads back as {8'h00, count, 16'h0000}.
- R4: A decrement pulse lowers the count by one, and a count of zero stays at zero. When a semaphore write and a decrement arrive in the same cycle, the result is (count+added) mod 256 minus one, saturating at zero.
- R5: A completion pulse on channel n sets control 1 bit n. A write to control 1 loads the status bits and the enable bits from the written data.
- R6: The cycle after a completion on channel n, irq line n rises if control 1 bit 16+n is set and the completion's interrupt flag is high. Otherwise it does not rise. It stays high until status bit n is cleared by a write.
- R7: A write to control 0 stores the data, with one exception. If the written value differs from the old value only in bit 31, and that bit goes from 0 to 1, bit 30 is also set.
- R8: In the cycle after a write to control 1, start line n pulses for exactly one cycle for each channel whose next-command word is nonzero and whose written status bit n is 0.
- R9: In the cycle after a write to a channel's semaphore word, that channel's start line pulses for one cycle.
- R10: Offsets that map to no register read as zero, and writes to them change no register and produce no start. This covers the gap between 0x50 and CH_BASE and everything past the last channel.
- R11: After reset every register, count, irq line and start line is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address of the access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| ch_done_i | input | NUM_CH | Per-channel descriptor completion pulse |
| ch_irq_req_i | input | NUM_CH | The completing descriptor requests an interrupt |
| ch_sem_dec_i | input | NUM_CH | Per-channel semaphore decrement pulse |
| ch_irq_o | output | NUM_CH | Per-channel interrupt line |
| ch_start_o | output | NUM_CH | Per-channel start request, one-cycle pulse |

## Verification
The bench builds the default parameters: four channels, channel base 0x100, and a 12-bit address. With these values there is an unmapped gap from 0x50 to 0xF0, and unmapped space above 0x2C0. Writes to both regions can be shown to leave every register untouched. Four channels are enough for one control 1 write to start some channels and skip others, whether the reason is a zero next-command word or a set status bit. They also let enabled, disabled and unrequested completions be told apart on separate irq lines. Counts are driven through wrap-around at 256 and down into saturation at zero, including the cycle where a write and a decrement coincide.

// File: rtl/dma_rb_pkg.sv
`timescale 1ns/1ps
package dma_rb_pkg;
  localparam int unsigned REG_STRIDE = 16;
  localparam int unsigned NUM_GLB    = 5;
  localparam int unsigned CH_WORDS   = 7;

  typedef enum logic [2:0] {
    G_CTRL0 = 3'd0, G_CTRL1 = 3'd1, G_CTRL2 = 3'd2, G_SELA = 3'd3, G_SELB = 3'd4
  } glb_word_e;

  typedef enum logic [2:0] {
    C_CUR = 3'd0, C_NEXT = 3'd1, C_CMD = 3'd2, C_BUF = 3'd3,
    C_SEM = 3'd4, C_DBG1 = 3'd5, C_DBG2 = 3'd6
  } ch_word_e;

  typedef struct packed {
    logic       glb;
    logic       chn;
    logic [3:0] ch;
    logic [2:0] word;
  } rb_sel_t;
endpackage

// File: rtl/dma_rb_decode.sv
`timescale 1ns/1ps
module dma_rb_decode
  import dma_rb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned CH_BASE = 256
) (
  input  logic [ADDR_W-1:0] addr_i,
  output rb_sel_t           sel_o
);
  localparam int unsigned WI_W = ADDR_W - 4;
  localparam logic [WI_W-1:0] GLB_END = WI_W'(NUM_GLB);
  localparam logic [WI_W-1:0] CH_LO   = WI_W'(CH_BASE / REG_STRIDE);
  localparam logic [WI_W-1:0] CH_HI   = WI_W'(CH_BASE / REG_STRIDE + NUM_CH * CH_WORDS);
  localparam logic [WI_W-1:0] STEP    = WI_W'(CH_WORDS);

  logic [WI_W-1:0] wi, rel, quo, rem;
  logic            unused_bits;

  assign wi  = addr_i[ADDR_W-1:4];
  assign rel = wi - CH_LO;
  assign quo = rel / STEP;
  assign rem = rel % STEP;
  assign unused_bits = ^{addr_i[3:0], quo[WI_W-1:4], rem[WI_W-1:3]};

  always_comb begin
    sel_o = '0;
    if (wi < GLB_END) begin
      sel_o.glb  = 1'b1;
      sel_o.word = wi[2:0];
    end else if (wi >= CH_LO && wi < CH_HI) begin
      sel_o.chn  = 1'b1;
      sel_o.ch   = quo[3:0];
      sel_o.word = rem[2:0];
    end
  end
endmodule

// File: rtl/dma_rb_chan.sv
`timescale 1ns/1ps
module dma_rb_chan
  import dma_rb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [2:0]  word_i,
  input  logic [31:0] wdata_i,
  input  logic        dec_i,
  output logic [31:0] rdata_o,
  output logic        sem_wr_o,
  output logic        next_nz_o
);
  logic [31:0] cur_q, next_q, cmd_q, buf_q;
  logic [7:0]  cnt_q, cnt_d, inc, sum;

  assign sem_wr_o  = wr_i && word_i == C_SEM;
  assign next_nz_o = |next_q;
  assign inc       = sem_wr_o ? wdata_i[7:0] : 8'd0;
  assign sum       = cnt_q + inc;
  assign cnt_d     = !dec_i ? sum : (sum == 8'd0 ? 8'd0 : sum - 8'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      next_q <= '0;
      cmd_q  <= '0;
      buf_q  <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (wr_i) begin
        case (word_i)
          C_CUR:   cur_q  <= wdata_i;
          C_NEXT:  next_q <= wdata_i;
          C_CMD:   cmd_q  <= wdata_i;
          C_BUF:   buf_q  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (word_i)
      C_CUR:   rdata_o = cur_q;
      C_NEXT:  rdata_o = next_q;
      C_CMD:   rdata_o = cmd_q;
      C_BUF:   rdata_o = buf_q;
      C_SEM:   rdata_o = {8'h00, cnt_q, 16'h0000};
      default: rdata_o = '0;
    endcase
  end

  p_dec_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !sem_wr_o && cnt_q == 8'd0 |=> cnt_q == 8'd0);
  p_dec_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !sem_wr_o && cnt_q != 8'd0 |=> cnt_q == $past(cnt_q) - 8'd1);
  p_cnt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sem_wr_o && !dec_i |=> $stable(cnt_q));
endmodule

// File: rtl/dma_rb_glb.sv
`timescale 1ns/1ps
module dma_rb_glb
  import dma_rb_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        word_i,
  input  logic [31:0]       wdata_i,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] irq_req_i,
  input  logic [NUM_CH-1:0] next_nz_i,
  input  logic [NUM_CH-1:0] sem_wr_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic [NUM_CH-1:0] start_o
);
  localparam logic [31:0] RST_BIT  = 32'h8000_0000;
  localparam logic [31:0] GATE_BIT = 32'h4000_0000;

  logic [31:0]       ctrl0_q, ctrl2_q, sela_q, selb_q, ctrl1_rd;
  logic [NUM_CH-1:0] stat_q, stat_d, en_q, irq_q, irq_d, start_q, start_d;
  logic              c0_wr, c1_wr;

  assign c0_wr = wr_i && word_i == G_CTRL0;
  assign c1_wr = wr_i && word_i == G_CTRL1;

  assign stat_d  = (c1_wr ? wdata_i[NUM_CH-1:0] : stat_q) | done_i;
  assign irq_d   = (irq_q & stat_d) | (done_i & en_q & irq_req_i);
  assign start_d = (c1_wr ? (next_nz_i & ~wdata_i[NUM_CH-1:0]) : '0) | sem_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl0_q <= '0;
      ctrl2_q <= '0;
      sela_q  <= '0;
      selb_q  <= '0;
      stat_q  <= '0;
      en_q    <= '0;
      irq_q   <= '0;
      start_q <= '0;
    end else begin
      stat_q  <= stat_d;
      irq_q   <= irq_d;
      start_q <= start_d;
      if (c1_wr) en_q <= wdata_i[16 +: NUM_CH];
      if (c0_wr) begin
        // soft-reset request also gates the clock
        if ((ctrl0_q ^ wdata_i) == RST_BIT && !ctrl0_q[31]) ctrl0_q <= wdata_i | GATE_BIT;
        else ctrl0_q <= wdata_i;
      end
      if (wr_i && word_i == G_CTRL2) ctrl2_q <= wdata_i;
      if (wr_i && word_i == G_SELA)  sela_q  <= wdata_i;
      if (wr_i && word_i == G_SELB)  selb_q  <= wdata_i;
    end
  end

  always_comb begin
    ctrl1_rd                 = '0;
    ctrl1_rd[NUM_CH-1:0]     = stat_q;
    ctrl1_rd[16 +: NUM_CH]   = en_q;
  end

  always_comb begin
    case (word_i)
      G_CTRL0: rdata_o = ctrl0_q;
      G_CTRL1: rdata_o = ctrl1_rd;
      G_CTRL2: rdata_o = ctrl2_q;
      G_SELA:  rdata_o = sela_q;
      G_SELB:  rdata_o = selb_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o   = irq_q;
  assign start_o = start_q;

  p_done_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c1_wr |=> ($past(done_i) & ~stat_q) == '0);
  p_irq_in_stat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q & ~stat_q) == '0);
  p_irq_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_q & ~$past(irq_q) & ~$past(done_i & en_q & irq_req_i)) == '0);
  p_sem_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($past(sem_wr_i) & ~start_q) == '0);
  p_start_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q != '0 |-> $past(c1_wr) || $past(sem_wr_i) != '0);
  p_gate_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c0_wr && !ctrl0_q[31] && wdata_i == (ctrl0_q | RST_BIT) |=> ctrl0_q[30] && ctrl0_q[31]);
endmodule

// File: rtl/dma_regbank.sv
`timescale 1ns/1ps
module dma_regbank
  import dma_rb_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned CH_BASE = 256,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [NUM_CH-1:0] ch_done_i,
  input  logic [NUM_CH-1:0] ch_irq_req_i,
  input  logic [NUM_CH-1:0] ch_sem_dec_i,
  output logic [NUM_CH-1:0] ch_irq_o,
  output logic [NUM_CH-1:0] ch_start_o
);
  rb_sel_t           sel;
  logic [31:0]       glb_rdata, ch_rdata_sel;
  logic [31:0]       ch_rdata [NUM_CH];
  logic [NUM_CH-1:0] sem_wr, next_nz;

  dma_rb_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_BASE(CH_BASE)) u_dec (
    .addr_i (reg_addr_i),
    .sel_o  (sel)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dma_rb_chan u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (reg_we_i && sel.chn && sel.ch == 4'(i)),
      .word_i    (sel.word),
      .wdata_i   (reg_wdata_i),
      .dec_i     (ch_sem_dec_i[i]),
      .rdata_o   (ch_rdata[i]),
      .sem_wr_o  (sem_wr[i]),
      .next_nz_o (next_nz[i])
    );
  end

  dma_rb_glb #(.NUM_CH(NUM_CH)) u_glb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_we_i && sel.glb),
    .word_i    (sel.word),
    .wdata_i   (reg_wdata_i),
    .done_i    (ch_done_i),
    .irq_req_i (ch_irq_req_i),
    .next_nz_i (next_nz),
    .sem_wr_i  (sem_wr),
    .rdata_o   (glb_rdata),
    .irq_o     (ch_irq_o),
    .start_o   (ch_start_o)
  );

  always_comb begin
    ch_rdata_sel = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel.ch == 4'(i)) ch_rdata_sel = ch_rdata[i];
    end
  end

  assign reg_rdata_o = sel.glb ? glb_rdata : (sel.chn ? ch_rdata_sel : '0);

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel.glb && !sel.chn |-> reg_rdata_o == '0);
  p_unmapped_nostart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && !sel.glb && !sel.chn && ch_sem_dec_i == '0 |=> ch_start_o == '0);
endmodule

// File: tb/dma_regbank_tb_top.sv
`timescale 1ns/1ps
module dma_regbank_tb_top;
  localparam int NCH  = 4;
  localparam int BASE = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  done = '0, irq_req = '0, sem_dec = '0;
  logic [3:0]  irq, start;

  int n_chk = 0, n_fail = 0;

  logic [31:0] m_c0, m_c1, m_c2, m_sa, m_sb;
  logic [31:0] m_reg [NCH][4];
  logic [7:0]  m_cnt [NCH];
  logic [3:0]  m_irq;

  always #2.5 clk = ~clk;

  dma_regbank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ch_done_i(done),
    .ch_irq_req_i(irq_req), .ch_sem_dec_i(sem_dec), .ch_irq_o(irq), .ch_start_o(start)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    int wi, k;
    wi = int'(a[11:4]);
    if (wi < 5) begin
      case (wi)
        0: return m_c0;
        1: return m_c1;
        2: return m_c2;
        3: return m_sa;
        default: return m_sb;
      endcase
    end
    k = wi - BASE / 16;
    if (k >= 0 && k < NCH * 7) begin
      if (k % 7 < 4) return m_reg[k / 7][k % 7];
      if (k % 7 == 4) return {8'h00, m_cnt[k / 7], 16'h0000};
      return 32'h0;
    end
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    int k;
    k = int'(a[11:4]) - BASE / 16;
    if (a[11:4] < 8'd5) return "R1";
    if (k >= 0 && k < NCH * 7) return (k % 7 == 4) ? "R3" : "R2";
    return "R10";
  endfunction

  task automatic check_all();
    logic [11:0] list [39];
    for (int i = 0; i < 5; i++) list[i] = 12'(i * 16);
    for (int i = 0; i < NCH * 7; i++) list[5 + i] = 12'(BASE + i * 16);
    list[33] = 12'h050; list[34] = 12'h0a0; list[35] = 12'h0f0;
    list[36] = 12'h2c0; list[37] = 12'h3f8; list[38] = 12'hff0;
    for (int i = 0; i < 39; i++) begin
      addr = list[i];
      #0.1;
      chk(tag_of(list[i]), rdata, exp_rd(list[i]));
    end
    chk("R6 irq", 32'(irq), 32'(m_irq));
  endtask

  // one clock: optional write plus decrements; checks the start pulse
  task automatic cyc(input logic w, input logic [11:0] a, input logic [31:0] d,
                     input logic [3:0] dec, input string tag);
    logic [3:0] es;
    logic [7:0] inc [NCH];
    logic [7:0] sum;
    int wi, k;
    @(negedge clk);
    we = w; addr = a; wdata = d; sem_dec = dec;
    es = '0;
    for (int c = 0; c < NCH; c++) inc[c] = 8'd0;
    if (w) begin
      wi = int'(a[11:4]);
      k  = wi - BASE / 16;
      if (wi < 5) begin
        case (wi)
          0: m_c0 = ((m_c0 ^ d) == 32'h8000_0000 && !m_c0[31]) ? (d | 32'h4000_0000) : d;
          1: begin
               m_c1 = d & 32'h000f_000f;
               m_irq = m_irq & d[3:0];
               for (int c = 0; c < NCH; c++) es[c] = (m_reg[c][1] != 0) && !d[c];
             end
          2: m_c2 = d;
          3: m_sa = d;
          default: m_sb = d;
        endcase
      end else if (k >= 0 && k < NCH * 7) begin
        if (k % 7 < 4) m_reg[k / 7][k % 7] = d;
        else if (k % 7 == 4) begin
          inc[k / 7] = d[7:0];
          es[k / 7] = 1'b1;
        end
      end
    end
    for (int c = 0; c < NCH; c++) begin
      sum = m_cnt[c] + inc[c];
      if (dec[c]) sum = (sum == 8'd0) ? 8'd0 : sum - 8'd1;
      m_cnt[c] = sum;
    end
    @(posedge clk);
    #1;
    chk(tag, 32'(start), 32'(es));
    we = 1'b0; sem_dec = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, a, d, 4'h0, tag);
  endtask

  task automatic complete(input logic [3:0] mask, input logic [3:0] req);
    @(negedge clk);
    done = mask; irq_req = req;
    m_irq = m_irq | (mask & m_c1[19:16] & req);
    m_c1  = m_c1 | 32'(mask);
    @(posedge clk);
    #1;
    chk("R6 irq after done", 32'(irq), 32'(m_irq));
    done = '0; irq_req = '0;
    addr = 12'h010;
    #0.1;
    chk("R5 status", rdata, m_c1);
  endtask

  function automatic logic [11:0] sem_addr(input int c);
    return 12'(BASE + c * 112 + 64);
  endfunction

  initial begin
    logic [11:0] ulist [6];
    void'($urandom(32'd20240611));
    m_c0 = 0; m_c1 = 0; m_c2 = 0; m_sa = 0; m_sb = 0; m_irq = 0;
    for (int c = 0; c < NCH; c++) begin
      m_cnt[c] = 0;
      for (int w = 0; w < 4; w++) m_reg[c][w] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R11: everything zero in reset
    check_all();
    chk("R11 start", 32'(start), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1: plain global registers
    wr(12'h020, 32'hdead_beef, "R1 no start");
    wr(12'h030, 32'h1234_5678, "R1 no start");
    wr(12'h04c, 32'hcafe_f00d, "R1 no start");
    check_all();

    // R7: reset bit sets gate bit only for a lone 0->1 change of bit 31
    wr(12'h000, 32'h8000_0000, "R7");
    addr = 12'h000; #0.1; chk("R7 gate set", rdata, 32'hc000_0000);
    wr(12'h000, 32'h0000_0000, "R7");
    wr(12'h000, 32'h8000_0001, "R7");
    addr = 12'h000; #0.1; chk("R7 two bits changed", rdata, 32'h8000_0001);
    wr(12'h000, 32'h0000_0001, "R7");
    addr = 12'h000; #0.1; chk("R7 falling bit", rdata, 32'h0000_0001);
    wr(12'h000, 32'h8000_0001, "R7");
    addr = 12'h000; #0.1; chk("R7 gate set again", rdata, 32'hc000_0001);

    // R2: channel words
    for (int c = 0; c < NCH; c++)
      for (int w = 0; w < 4; w++)
        wr(12'(BASE + c * 112 + w * 16), 32'(c * 16 + w + 1) << (w * 4), "R2 no start");
    wr(12'(BASE + 80), 32'hffff_ffff, "R2 debug write");
    check_all();

    // R3 / R9: semaphore add with wrap and start pulse
    wr(sem_addr(1), 32'h0000_0005, "R9 sem start");
    wr(sem_addr(1), 32'hffff_01ff, "R9 sem start");
    addr = sem_addr(1); #0.1; chk("R3 wrap", rdata, 32'h0004_0000);

    // R4: decrement to and below zero, and combined with a write
    for (int i = 0; i < 6; i++) cyc(1'b0, 12'h000, 0, 4'b0010, "R4 no start");
    addr = sem_addr(1); #0.1; chk("R4 floor", rdata, 32'h0);
    cyc(1'b1, sem_addr(2), 32'h0000_0003, 4'b0100, "R4 combined start");
    addr = sem_addr(2); #0.1; chk("R4 combined", rdata, 32'h0002_0000);
    cyc(1'b1, sem_addr(3), 32'h0000_0000, 4'b1000, "R4 zero write dec");
    addr = sem_addr(3); #0.1; chk("R4 zero combined", rdata, 32'h0);

    // R8: control 1 write starts channels with a nonzero next word and clear status
    wr(12'(BASE + 0 * 112 + 16), 32'h0, "R8 setup");
    wr(12'(BASE + 2 * 112 + 16), 32'h0, "R8 setup");
    wr(12'h010, 32'h0003_0002, "R8 start mask");
    check_all();

    // R5 / R6: completions with enables and requests
    complete(4'b0001, 4'b0001);
    complete(4'b0010, 4'b0000);
    complete(4'b0100, 4'b0100);
    complete(4'b1000, 4'b1000);
    wr(12'h010, 32'h0003_000e, "R8 clear status");
    chk("R6 irq cleared", 32'(irq), 32'h0);
    check_all();

    // R10: unmapped writes change nothing
    ulist[0] = 12'h050; ulist[1] = 12'h0a0; ulist[2] = 12'h0f0;
    ulist[3] = 12'h2c0; ulist[4] = 12'h3f8; ulist[5] = 12'hff0;
    for (int i = 0; i < 6; i++) wr(ulist[i], 32'hffff_ffff, "R10 no start");
    check_all();

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [11:0] a;
      logic [3:0] dec;
      r = int'($urandom % 40);
      if (r < 5) a = 12'(r * 16);
      else if (r < 33) a = 12'(BASE + (r - 5) * 16);
      else if (r < 39) a = ulist[r - 33];
      else a = 12'h1f0;
      a[3:0] = 4'($urandom);
      dec = '0;
      for (int c = 0; c < NCH; c++) dec[c] = ($urandom % 4) == 0;
      cyc(($urandom % 5) != 0, a, $urandom, dec, "R8 R9 random start");
      if (n % 100 == 99) check_all();
    end
    check_all();
    finish_up();
  end
endmodule